// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the per-processor countdown timer of an interrupt controller. Software sets it up through a small register port. A divide register picks the count rate, which is the input clock divided by a power of two. A control entry chooses one-shot or periodic operation, masks the timer and holds the interrupt vector. Writing a start value into the initial-count register launches a countdown, and the live count can be read back at any time.

When the count steps down to zero, the timer raises a one-cycle interrupt request tagged with the programmed vector, unless the timer is masked. In one-shot mode the count then stays at zero. In periodic mode the start value is reloaded on the next prescaled tick, so each period lasts initial count + 1 ticks. The interrupt request is edge-style and feeds the controller's priority logic, which lies outside this block.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset, the control entry reads 0x0001_0000 (mask set, one-shot, vector 0), and the initial count, current count and divide register all read 0. The interrupt pulse is low.
- R2: Register selects are 0 for divide, 1 for initial count, 2 for current count and 3 for the control entry. The divide register keeps write bits 0, 1 and 3, and every other bit reads as 0.
- R3: The divide code is {bit3, bit1, bit0}, with bit 3 as the MSB. The shift is (code + 1) mod 8, and a prescaled tick occurs every 2^shift clocks, so code 7 divides by 1 and code 0 divides by 2. Writing the initial count restarts the prescaler, and the first decrement lands 2^shift clocks after that write edge.
- R4: In the control entry, bit 17 selects periodic mode, bit 16 masks the timer and bits 7:0 hold the vector. All other bits read as 0.
- R5: Writing a nonzero value to the initial count loads it into the current count at the write edge and starts counting down.
- R6: In one-shot mode the count steps down to 0, stays there and raises exactly one interrupt.
- R7: In periodic mode the count goes from 0 back to the initial value on the next tick. Interrupts recur every (initial count + 1) ticks.
- R8: While bit 16 is set, no interrupt is raised, but the count still runs as in R6 and R7.
- R9: The interrupt is a single-cycle pulse, and the vector output carries the programmed vector in that cycle. The pulse is high in the first cycle in which the count reads 0.
- R10: The current-count register is read-only, and writes to it change nothing.
- R11: Writing 0 to the initial count stops the timer: the count reads 0 and no interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the selected register (combinational) |
| irqPulse | output | 1 | One-cycle expiry interrupt request |
| irqVector | output | 8 | Vector accompanying the interrupt |

## Verification
The hardest case to reach is the exact cycle of each expiry under the slow divide codes, especially the periodic wrap from 0 back to the initial value, which can come thousands of clocks after the start. The bench restarts the prescaler by writing the initial count last. It then samples every cycle for more than two full periods and compares each sample with a closed-form count and pulse expectation. Random start values, divide codes, modes and masks are mixed with directed cases: a zero start value, a count of one, and divide-by-1.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int CODE_W       = 3;
  localparam int MAX_SHIFT    = (1 << CODE_W) - 1;
  localparam int VEC_W        = 8;
  localparam int PERIODIC_BIT = 17;
  localparam int MASK_BIT     = 16;

  typedef enum logic [1:0] {
    SEL_DIVIDE = 2'd0,
    SEL_INIT   = 2'd1,
    SEL_CUR    = 2'd2,
    SEL_ENTRY  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic load;
    logic tick;
    logic periodic;
  } ctlStrobe_t;
endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  input  logic [DATA_W-1:0] curCount,
  output ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] initValue,
  output logic [DATA_W-1:0] rdData,
  output logic              irqPulse,
  output logic [VEC_W-1:0]  irqVector,
  output logic              maskBit,
  output logic              periodicBit
);
  logic [CODE_W-1:0]    divCode;
  logic [VEC_W-1:0]     entryVec;
  logic [DATA_W-1:0]    initReg;
  logic [MAX_SHIFT-1:0] preCnt;
  logic [CODE_W-1:0]    shiftAmt;
  logic [MAX_SHIFT-1:0] lowMask;
  logic                 tick;
  logic                 loadNow;
  regSel_e              sel;

  assign sel      = regSel_e'(regAddr);
  assign loadNow  = wrEn && (sel == SEL_INIT);
  assign shiftAmt = divCode + CODE_W'(1);
  assign lowMask  = ~({MAX_SHIFT{1'b1}} << shiftAmt);
  assign tick     = &(preCnt | ~lowMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCode     <= '0;
      entryVec    <= '0;
      maskBit     <= 1'b1;
      periodicBit <= 1'b0;
      initReg     <= '0;
    end else if (wrEn) begin
      case (sel)
        SEL_DIVIDE: divCode <= {wrData[3], wrData[1:0]};
        SEL_INIT:   initReg <= wrData;
        SEL_ENTRY: begin
          entryVec    <= wrData[VEC_W-1:0];
          maskBit     <= wrData[MASK_BIT];
          periodicBit <= wrData[PERIODIC_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (loadNow) preCnt <= '0;
    else              preCnt <= preCnt + MAX_SHIFT'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPulse  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqPulse <= expire && !maskBit;
      if (expire && !maskBit) irqVector <= entryVec;
    end
  end

  always_comb begin
    strobe.load     = loadNow;
    strobe.tick     = tick && !loadNow;
    strobe.periodic = periodicBit;
  end

  assign initValue = wrData;

  always_comb begin
    rdData = '0;
    case (sel)
      SEL_DIVIDE: rdData[3:0] = {divCode[2], 1'b0, divCode[1:0]};
      SEL_INIT:   rdData = initReg;
      SEL_CUR:    rdData = curCount;
      SEL_ENTRY: begin
        rdData[VEC_W-1:0]   = entryVec;
        rdData[MASK_BIT]     = maskBit;
        rdData[PERIODIC_BIT] = periodicBit;
      end
      default: rdData = '0;
    endcase
  end

  logic [DATA_W-1:0] reloadReg;
  assign reloadReg = initReg;
endmodule

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] loadValue,
  input  logic [DATA_W-1:0] reloadValue,
  output logic [DATA_W-1:0] curCount,
  output logic              expire
);
  logic active;
  logic atZero;
  logic atOne;

  assign atZero = (curCount == '0);
  assign atOne  = (curCount == DATA_W'(1));
  assign expire = strobe.tick && active && atOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCount <= '0;
      active   <= 1'b0;
    end else if (strobe.load) begin
      curCount <= loadValue;
      active   <= (loadValue != '0);
    end else if (strobe.tick && active) begin
      if (atZero) begin
        if (strobe.periodic) curCount <= reloadValue;
        else                 active   <= 1'b0;
      end else begin
        curCount <= curCount - DATA_W'(1);
        if (atOne && !strobe.periodic) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqPulse,
  output logic [VEC_W-1:0]  irqVector
);
  ctlStrobe_t        strobe;
  logic [DATA_W-1:0] loadValue;
  logic [DATA_W-1:0] curCount;
  logic              expire;
  logic              maskBit;
  logic              periodicBit;

  cdt_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .expire(expire), .curCount(curCount), .strobe(strobe), .initValue(loadValue),
    .rdData(rdData), .irqPulse(irqPulse), .irqVector(irqVector),
    .maskBit(maskBit), .periodicBit(periodicBit)
  );

  cdt_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadValue(loadValue),
    .reloadValue(uCtrl.reloadReg), .curCount(curCount), .expire(expire)
  );
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              irqPulse,
  input logic [DATA_W-1:0] curCount,
  input logic              maskBit,
  input logic              periodicBit
);
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  assert_pulse_at_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (curCount == '0));

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> !$past(maskBit));

  assert_load_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 2'd1) |=> (curCount == $past(wrData)));

  assert_oneshot_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curCount == '0 && !periodicBit && !(wrEn && regAddr == 2'd1)) |=> (curCount == '0));
endmodule

bind irq_countdown_timer cdt_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .irqPulse(irqPulse), .curCount(curCount), .maskBit(maskBit), .periodicBit(periodicBit)
);

// File: tb/tb_irq_countdown_timer.sv
`timescale 1ns/1ps
module tb_irq_countdown_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regAddr = 2'd2;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqPulse;
  logic [7:0]  irqVector;

  int checkCount = 0;
  int failCount  = 0;

  always #5 clk = ~clk;

  irq_countdown_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .irqPulse(irqPulse), .irqVector(irqVector)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0; regAddr = 2'd2;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1;
    v = rdData;
    regAddr = 2'd2;
  endtask

  function automatic int shiftOf(input int code);
    return (code + 1) % 8;
  endfunction

  function automatic longint expCount(input longint n, input int sh, input bit per, input longint c);
    longint t;
    t = c >> sh;
    if (n == 0) return 0;
    if (!per) return (t >= n) ? 0 : n - t;
    return n - (t % (n + 1));
  endfunction

  function automatic bit expIrq(input longint n, input int sh, input bit per, input bit msk, input longint c);
    longint t;
    if (msk || n == 0) return 0;
    if ((c % (64'd1 << sh)) != 0) return 0;
    t = c >> sh;
    if (t < n) return 0;
    if (!per) return t == n;
    return ((t - n) % (n + 1)) == 0;
  endfunction

  // Runs one countdown; divide code is given as {bit3,bit1,bit0}.
  task automatic runCase(input int n, input int code, input bit per, input bit msk,
                         input int vec, input string req);
    int sh;
    int cycles;
    int cntErr;
    int irqErr;
    longint badAct;
    longint badExp;
    longint irqAct;
    longint irqExp;
    logic [31:0] divWord;
    sh = shiftOf(code);
    divWord = {28'd0, code[2], 1'b0, code[1:0]};
    writeReg(2'd0, divWord);
    writeReg(2'd3, (32'(per) << 17) | (32'(msk) << 16) | 32'(vec));
    writeReg(2'd1, 32'(n));
    check(rdData == 32'(n), "R5", "count right after load", rdData, n);
    cycles = (2 * n + 3) << sh;
    cntErr = 0; irqErr = 0; badAct = 0; badExp = 0; irqAct = 0; irqExp = 0;
    for (int c = 1; c <= cycles; c++) begin
      @(posedge clk);
      #1;
      if (rdData != 32'(expCount(n, sh, per, c))) begin
        if (cntErr == 0) begin badAct = rdData; badExp = expCount(n, sh, per, c); end
        cntErr++;
      end
      if (irqPulse != expIrq(n, sh, per, msk, c) ||
          (irqPulse && irqVector != 8'(vec))) begin
        if (irqErr == 0) begin irqAct = {irqPulse, irqVector}; irqExp = {expIrq(n, sh, per, msk, c), 8'(vec)}; end
        irqErr++;
      end
    end
    check(cntErr == 0, req, "count trace (R3 timing)", badAct, badExp);
    check(irqErr == 0, msk ? "R8" : "R9", "irq pulse/vector trace", irqAct, irqExp);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(irqPulse == 1'b0, "R1", "irq after reset", irqPulse, 0);
    readReg(2'd3, v); check(v == 32'h0001_0000, "R1", "entry reset", v, 32'h0001_0000);
    readReg(2'd1, v); check(v == 0, "R1", "initial count reset", v, 0);
    readReg(2'd2, v); check(v == 0, "R1", "current count reset", v, 0);
    readReg(2'd0, v); check(v == 0, "R1", "divide reset", v, 0);

    writeReg(2'd0, 32'hFFFF_FFFF);
    readReg(2'd0, v); check(v == 32'h0000_000B, "R2", "divide keeps bits 0,1,3", v, 32'hB);
    writeReg(2'd3, 32'hFFFF_FFFF);
    readReg(2'd3, v); check(v == 32'h0003_00FF, "R4", "entry field readback", v, 32'h300FF);

    runCase(5, 7, 1'b0, 1'b0, 8'h41, "R6");
    writeReg(2'd2, 32'h0000_1234);
    readReg(2'd2, v); check(v == 0, "R10", "write to current count ignored", v, 0);
    runCase(1, 7, 1'b1, 1'b0, 8'h22, "R7");
    runCase(4, 0, 1'b1, 1'b0, 8'h90, "R7");
    runCase(3, 2, 1'b1, 1'b1, 8'h55, "R8");
    runCase(6, 3, 1'b0, 1'b0, 8'hA7, "R3");
    runCase(0, 7, 1'b1, 1'b0, 8'h11, "R11");
    for (int i = 0; i < 8; i++) begin
      runCase(1 + int'($urandom % 12), int'($urandom % 8), 1'(($urandom % 2)),
              1'(($urandom % 4) == 0), int'($urandom % 256), "R7");
    end
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #2_000_000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #22 rstN = 1'b1;
  end
endmodule